// File: doc/BRIEF.md
# I2C Command Stream Engine

This block turns a byte-coded command stream from a host into I2C bus activity. Command bytes arrive on a byte-wide valid/ready input. They are grouped into packets of up to `PKT_BYTES` bytes. An open byte starts each packet and a close byte ends it. Between them, single-byte opcodes issue START and STOP conditions, set the bus rate, and run write and read bursts. The burst length is carried in the low bits of the opcode.

The block drives SCL and SDA as open-drain lines through active-low output enables. It samples the SDA pad to read data and acknowledge bits. Every byte read from the bus leaves on `out_data` with a one-cycle `out_valid` strobe. The acknowledge seen after the most recent written byte is kept in a status flag. While any bus operation is running, the input stream is held off.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset, both output enables are high (lines released), `in_ready` is 1, `out_valid` is 0 and `ack_seen` is 0.
- R2: Outside a packet, every byte except the open byte 0xAA is ignored. A START opcode (0x74) received there produces no bus activity.
- R3: Opcode 0x74 makes SDA fall while SCL is high (START). Opcode 0x75 makes SDA rise while SCL is high (STOP).
- R4: Opcode 0x80|n, with n in bits 4:0, transmits the next n input bytes MSB first. Each byte gets a ninth clock with SDA released.
- R5: After each written byte, `ack_seen` becomes 1 if the target held SDA low on the ninth clock and 0 otherwise. A missing acknowledge does not stop the remaining bytes of the burst.
- R6: Opcode 0xC0|n, with n from 1 to 32 in bits 5:0 (values above 32 count as 32), reads n bytes. The block holds SDA low on the ninth clock of each of them. Each byte appears on `out_data` together with a single-cycle `out_valid`.
- R7: The bare opcode 0xC0 reads exactly one byte, and the block leaves SDA released on its ninth clock (NACK).
- R8: Opcode 0x60|s, with s in bits 1:0, selects the bus rate: 0 is 20 kHz, 1 is 100 kHz, 2 is 400 kHz, 3 is 750 kHz. Rate 1 applies after reset. SCL stays high for 2*max(1, CLK_HZ/(4*rate)) clock cycles per bit.
- R9: `in_ready` is 0 from the cycle after an opcode or data byte that starts a bus operation is accepted until that operation ends.
- R10: The close byte 0x00 ends the packet. Later opcodes are ignored until the next 0xAA.
- R11: A packet ends on its own after `PKT_BYTES` bytes, counted from 0xAA. Bytes still owed to a write burst are dropped, and the next byte is treated as outside a packet.
- R12: During a byte transfer, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Command stream byte |
| in_valid | input | 1 | Command byte valid |
| in_ready | output | 1 | Engine can take a command byte |
| out_data | output | 8 | Byte read from the bus |
| out_valid | output | 1 | One-cycle strobe for `out_data` |
| sda_i | input | 1 | SDA pad level |
| scl_oe_n | output | 1 | 0 pulls SCL low, 1 releases it |
| sda_oe_n | output | 1 | 0 pulls SDA low, 1 releases it |
| ack_seen | output | 1 | Acknowledge of the last written byte |

## Verification
Some properties are checked on every cycle. SDA must stay still while SCL is high inside a byte transfer. The START and STOP edges must fall within the SCL-high window. Input back-pressure must hold during each bus operation. The read strobe is a single pulse. The acknowledge flag may move only when a bus operation completes. Only the bench scenarios, run against a target model on the wires, can show the rest: the opcode decoding, the order and values of data bytes, the acknowledge and NACK pattern of a read burst, the SCL timing at each rate, and the packet-boundary and close-byte behaviour.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_XFER  = 2'd2,
    OP_NONE  = 2'd3
  } phy_op_e;

  typedef enum logic [2:0] {
    D_IDLE   = 3'd0,
    D_CMD    = 3'd1,
    D_WDATA  = 3'd2,
    D_WAIT_C = 3'd3,
    D_WAIT_W = 3'd4,
    D_WAIT_R = 3'd5
  } dec_st_e;

  localparam logic [7:0] OPC_OPEN  = 8'hAA;
  localparam logic [7:0] OPC_CLOSE = 8'h00;
  localparam logic [7:0] OPC_START = 8'h74;
  localparam logic [7:0] OPC_STOP  = 8'h75;
  localparam logic [2:0] GRP_WRITE = 3'b100;
  localparam logic [1:0] GRP_READ  = 2'b11;
  localparam logic [5:0] GRP_SPEED = 6'b011000;

  // clock cycles per quarter of an SCL bit for a rate selector
  function automatic int quarter_div(input int clk_hz, input int sel);
    int rate;
    int d;
    case (sel)
      0:       rate = 20000;
      1:       rate = 100000;
      2:       rate = 400000;
      default: rate = 750000;
    endcase
    d = clk_hz / (4 * rate);
    if (d < 1) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/i2c_bit_phy.sv
module i2c_bit_phy
  import i2c_cmd_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed,
  input  logic       req,
  input  phy_op_e    op,
  input  logic [7:0] wbyte,
  input  logic       rd,
  input  logic       nack,
  input  logic       sda_i,
  output logic       busy,
  output logic       done,
  output phy_op_e    op_act,
  output logic [7:0] rx_byte,
  output logic       ack_rx,
  output logic       scl_oe_n,
  output logic       sda_oe_n
);

  localparam int DIV0  = quarter_div(CLK_HZ, 0);
  localparam int DIV1  = quarter_div(CLK_HZ, 1);
  localparam int DIV2  = quarter_div(CLK_HZ, 2);
  localparam int DIV3  = quarter_div(CLK_HZ, 3);
  localparam int DIV_W = $clog2(DIV0 + 1);

  logic             busy_q, busy_n;
  phy_op_e          op_q, op_n;
  logic [1:0]       ph_q, ph_n;
  logic [3:0]       bit_q, bit_n;
  logic [7:0]       sh_q, sh_n;
  logic             rd_q, rd_n, nack_q, nack_n;
  logic [DIV_W-1:0] cnt_q, cnt_n, div_sel;
  logic             scl_lo_q, scl_lo_n, sda_lo_q, sda_lo_n;
  logic             done_q, done_n, ack_q, ack_n;

  always_comb begin
    case (speed)
      2'd0:    div_sel = DIV_W'(DIV0 - 1);
      2'd1:    div_sel = DIV_W'(DIV1 - 1);
      2'd2:    div_sel = DIV_W'(DIV2 - 1);
      default: div_sel = DIV_W'(DIV3 - 1);
    endcase
  end

  always_comb begin
    busy_n = busy_q; op_n = op_q; ph_n = ph_q; bit_n = bit_q; sh_n = sh_q;
    rd_n = rd_q; nack_n = nack_q; cnt_n = cnt_q; scl_lo_n = scl_lo_q;
    sda_lo_n = sda_lo_q; ack_n = ack_q; done_n = 1'b0;
    if (!busy_q && req) begin
      busy_n = 1'b1; op_n = op; ph_n = 2'd0; bit_n = 4'd0;
      sh_n = rd ? 8'hFF : wbyte; rd_n = rd; nack_n = nack; cnt_n = div_sel;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        cnt_n = cnt_q - 1'b1;
      end else begin
        cnt_n = div_sel;
        ph_n  = ph_q + 2'd1;
        case (op_q)
          OP_START: case (ph_q)
            2'd0: sda_lo_n = 1'b0;
            2'd1: scl_lo_n = 1'b0;
            2'd2: sda_lo_n = 1'b1;
            default: begin scl_lo_n = 1'b1; busy_n = 1'b0; done_n = 1'b1; end
          endcase
          OP_STOP: case (ph_q)
            2'd0: sda_lo_n = 1'b1;
            2'd1: scl_lo_n = 1'b0;
            2'd2: sda_lo_n = 1'b0;
            default: begin busy_n = 1'b0; done_n = 1'b1; end
          endcase
          default: case (ph_q)
            2'd0: sda_lo_n = (bit_q == 4'd8) ? (rd_q & ~nack_q) : ~sh_q[7];
            2'd1: scl_lo_n = 1'b0;
            2'd2: if (bit_q != 4'd8) sh_n = {sh_q[6:0], sda_i};
                  else ack_n = ~sda_i;
            default: begin
              scl_lo_n = 1'b1;
              if (bit_q == 4'd8) begin busy_n = 1'b0; done_n = 1'b1; end
              else bit_n = bit_q + 4'd1;
            end
          endcase
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; op_q <= OP_NONE; ph_q <= 2'd0; bit_q <= 4'd0; sh_q <= 8'h00;
      rd_q <= 1'b0; nack_q <= 1'b0; cnt_q <= '0; scl_lo_q <= 1'b0; sda_lo_q <= 1'b0;
      done_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      busy_q <= busy_n; op_q <= op_n; ph_q <= ph_n; bit_q <= bit_n; sh_q <= sh_n;
      rd_q <= rd_n; nack_q <= nack_n; cnt_q <= cnt_n; scl_lo_q <= scl_lo_n;
      sda_lo_q <= sda_lo_n; done_q <= done_n; ack_q <= ack_n;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign op_act   = op_q;
  assign rx_byte  = sh_q;
  assign ack_rx   = ack_q;
  assign scl_oe_n = ~scl_lo_q;
  assign sda_oe_n = ~sda_lo_q;

endmodule

// File: rtl/i2c_cmd_decoder.sv
module i2c_cmd_decoder
  import i2c_cmd_pkg::*;
#(
  parameter int PKT_BYTES = 32,
  parameter int RD_MAX    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       phy_done,
  input  logic [7:0] phy_rx,
  input  logic       phy_ack,
  output logic       req,
  output phy_op_e    op,
  output logic [7:0] wbyte,
  output logic       rd,
  output logic       nack,
  output logic [1:0] speed,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       ack_seen
);

  localparam int PW = (PKT_BYTES > 1) ? $clog2(PKT_BYTES) : 1;

  dec_st_e    st_q, st_n;
  logic [PW-1:0] pos_q, pos_n;
  logic [4:0] wcnt_q, wcnt_n;
  logic [5:0] rcnt_q, rcnt_n, rlen;
  logic       end_q, end_n, ack_q, ack_n, ov_q, ov_n;
  logic [1:0] spd_q, spd_n;
  logic [7:0] out_q, out_n, wb_q, wb_n;
  logic       req_q, req_n, rd_q, rd_n, nack_q, nack_n;
  phy_op_e    op_q, op_n;
  logic       acc, last;
  dec_st_e    fin, after;

  assign in_ready = (st_q == D_IDLE) || (st_q == D_CMD) || (st_q == D_WDATA);
  assign acc      = in_valid && in_ready;
  assign last     = (pos_q == PW'(PKT_BYTES - 1));
  assign fin      = end_q ? D_IDLE : D_CMD;
  assign after    = last ? D_IDLE : D_CMD;
  assign rlen     = (in_data[5:0] > 6'(RD_MAX)) ? 6'(RD_MAX) : in_data[5:0];

  always_comb begin
    st_n = st_q; pos_n = pos_q; wcnt_n = wcnt_q; rcnt_n = rcnt_q; end_n = end_q;
    ack_n = ack_q; ov_n = 1'b0; spd_n = spd_q; out_n = out_q; wb_n = wb_q;
    req_n = 1'b0; rd_n = rd_q; nack_n = nack_q; op_n = op_q;
    if (acc) begin
      if (st_q == D_IDLE && in_data == OPC_OPEN) pos_n = PW'(1);
      else pos_n = last ? '0 : pos_q + 1'b1;
    end
    case (st_q)
      D_IDLE: if (acc && in_data == OPC_OPEN) st_n = D_CMD;
      D_CMD: if (acc) begin
        st_n = after;
        if (in_data == OPC_CLOSE) begin
          st_n = D_IDLE;
        end else if (in_data == OPC_START || in_data == OPC_STOP) begin
          req_n = 1'b1; op_n = (in_data == OPC_START) ? OP_START : OP_STOP;
          end_n = last; st_n = D_WAIT_C;
        end else if (in_data[7:2] == GRP_SPEED) begin
          spd_n = in_data[1:0];
        end else if (in_data[7:5] == GRP_WRITE) begin
          if (in_data[4:0] != 5'd0 && !last) begin
            wcnt_n = in_data[4:0]; st_n = D_WDATA;
          end
        end else if (in_data[7:6] == GRP_READ) begin
          req_n = 1'b1; op_n = OP_XFER; rd_n = 1'b1; nack_n = (rlen == 6'd0);
          rcnt_n = (rlen == 6'd0) ? 6'd0 : rlen - 6'd1;
          end_n = last; st_n = D_WAIT_R;
        end
      end
      D_WDATA: if (acc) begin
        req_n = 1'b1; op_n = OP_XFER; rd_n = 1'b0; nack_n = 1'b0; wb_n = in_data;
        wcnt_n = wcnt_q - 5'd1; end_n = last; st_n = D_WAIT_W;
      end
      D_WAIT_C: if (phy_done) st_n = fin;
      D_WAIT_W: if (phy_done) begin
        ack_n = phy_ack;
        st_n  = (wcnt_q == 5'd0 || end_q) ? fin : D_WDATA;
      end
      D_WAIT_R: if (phy_done) begin
        ov_n = 1'b1; out_n = phy_rx;
        if (rcnt_q != 6'd0) begin
          req_n = 1'b1; nack_n = 1'b0; rcnt_n = rcnt_q - 6'd1;
        end else begin
          st_n = fin;
        end
      end
      default: st_n = D_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= D_IDLE; pos_q <= '0; wcnt_q <= 5'd0; rcnt_q <= 6'd0; end_q <= 1'b0;
      ack_q <= 1'b0; ov_q <= 1'b0; spd_q <= 2'd1; out_q <= 8'h00; wb_q <= 8'h00;
      req_q <= 1'b0; rd_q <= 1'b0; nack_q <= 1'b0; op_q <= OP_NONE;
    end else begin
      st_q <= st_n; pos_q <= pos_n; wcnt_q <= wcnt_n; rcnt_q <= rcnt_n; end_q <= end_n;
      ack_q <= ack_n; ov_q <= ov_n; spd_q <= spd_n; out_q <= out_n; wb_q <= wb_n;
      req_q <= req_n; rd_q <= rd_n; nack_q <= nack_n; op_q <= op_n;
    end
  end

  assign req       = req_q;
  assign op        = op_q;
  assign wbyte     = wb_q;
  assign rd        = rd_q;
  assign nack      = nack_q;
  assign speed     = spd_q;
  assign out_data  = out_q;
  assign out_valid = ov_q;
  assign ack_seen  = ack_q;

endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int PKT_BYTES = 32,
  parameter int RD_MAX    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       sda_i,
  output logic       scl_oe_n,
  output logic       sda_oe_n,
  output logic       ack_seen
);

  logic       phy_req, phy_rd, phy_nack, phy_busy, phy_done, phy_ack;
  logic [7:0] phy_wbyte, phy_rx;
  logic [1:0] phy_speed;
  phy_op_e    req_op, phy_op;

  i2c_cmd_decoder #(.PKT_BYTES(PKT_BYTES), .RD_MAX(RD_MAX)) u_dec (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .phy_done(phy_done), .phy_rx(phy_rx), .phy_ack(phy_ack),
    .req(phy_req), .op(req_op), .wbyte(phy_wbyte), .rd(phy_rd), .nack(phy_nack),
    .speed(phy_speed), .out_data(out_data), .out_valid(out_valid), .ack_seen(ack_seen)
  );

  i2c_bit_phy #(.CLK_HZ(CLK_HZ)) u_phy (
    .clk(clk), .rst_n(rst_n), .speed(phy_speed), .req(phy_req), .op(req_op),
    .wbyte(phy_wbyte), .rd(phy_rd), .nack(phy_nack), .sda_i(sda_i),
    .busy(phy_busy), .done(phy_done), .op_act(phy_op), .rx_byte(phy_rx),
    .ack_rx(phy_ack), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n)
  );

endmodule

// File: rtl/i2c_cmd_engine_chk.sv
module i2c_cmd_engine_chk
  import i2c_cmd_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    scl_oe_n,
  input logic    sda_oe_n,
  input logic    in_ready,
  input logic    out_valid,
  input logic    ack_seen,
  input logic    phy_busy,
  input logic    phy_done,
  input phy_op_e phy_op
);

  p_ready_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phy_busy |-> !in_ready);

  p_sda_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phy_busy) && $past(phy_op) == OP_XFER && !$stable(sda_oe_n))
      |-> (!scl_oe_n && !$past(scl_oe_n)));

  p_start_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phy_busy) && $past(phy_op) == OP_START && $fell(sda_oe_n)) |-> scl_oe_n);

  p_stop_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phy_busy) && $past(phy_op) == OP_STOP && $rose(sda_oe_n)) |-> scl_oe_n);

  p_rd_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_ack_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_seen) |-> $past(phy_done));

endmodule

bind i2c_cmd_engine i2c_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n),
  .in_ready(in_ready), .out_valid(out_valid), .ack_seen(ack_seen),
  .phy_busy(phy_busy), .phy_done(phy_done), .phy_op(phy_op)
);

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;

  logic       clk, rst_n, in_valid;
  logic [7:0] in_data;
  logic       in_ready, out_valid, scl_oe_n, sda_oe_n, ack_seen, sda_w;
  logic [7:0] out_data;

  i2c_cmd_engine #(.CLK_HZ(6_000_000)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .sda_i(sda_w), .scl_oe_n(scl_oe_n), .sda_oe_n(sda_oe_n), .ack_seen(ack_seen)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  // target model on the wires
  logic       slv_pull = 1'b0;
  bit         slv_ack = 1'b1;
  logic [7:0] seed = 8'h00;
  assign sda_w = sda_oe_n & ~slv_pull;
  int starts = 0, stops = 0, wn = 0, racks = 0, rnacks = 0;
  bit act = 0, rdm = 0, quiet = 0;
  int bn = 0, byn = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] wlog [0:63];
  logic [7:0] bv;

  always @(negedge sda_w) if (scl_oe_n === 1'b1) begin
    starts++; act = 1; bn = 0; byn = 0; rdm = 0; quiet = 0; slv_pull = 1'b0;
  end
  always @(posedge sda_w) if (scl_oe_n === 1'b1) begin
    stops++; act = 0;
  end
  always @(negedge scl_oe_n) if (act) begin
    bv = seed + 8'(byn);
    if (quiet) slv_pull = 1'b0;
    else if (byn != 0 && rdm) slv_pull = (bn < 8) ? ~bv[7 - bn] : 1'b0;
    else slv_pull = (bn == 8) ? slv_ack : 1'b0;
  end
  always @(posedge scl_oe_n) if (act) begin
    if (bn < 8) begin
      sh = {sh[6:0], sda_w}; bn++;
    end else begin
      if (byn != 0 && rdm) begin
        if (!sda_w) racks++; else begin rnacks++; quiet = 1; end
      end else begin
        if (wn < 64) wlog[wn] = sh;
        wn++;
        if (byn == 0) rdm = sh[0];
      end
      byn++; bn = 0;
    end
  end

  // SCL high-time meter and read capture
  int cyc = 0, t_rise = 0, hi_t = 0, rcount = 0;
  logic scl_prev = 1'b1;
  logic [7:0] rbuf [0:63];
  always @(negedge clk) begin
    cyc++;
    if (scl_oe_n && !scl_prev) t_rise = cyc;
    if (!scl_oe_n && scl_prev) hi_t = cyc - t_rise;
    scl_prev = scl_oe_n;
    if (out_valid) begin
      if (rcount < 64) rbuf[rcount] = out_data;
      rcount++;
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // {rate sel[23:22], read count[21:16], seed[15:8], SCL high cycles[7:0]}
  localparam logic [23:0] VEC [5] = '{
    {2'd1, 6'd3, 8'h10, 8'd30},
    {2'd2, 6'd1, 8'h3C, 8'd6},
    {2'd3, 6'd2, 8'hF0, 8'd4},
    {2'd0, 6'd1, 8'h01, 8'd150},
    {2'd2, 6'd5, 8'h80, 8'd6}
  };

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0h expected %0h", 0, 1);
    summary();
  end

  initial begin
    int s0, p0, w0, r0, a0, n0, n, sp;
    in_valid = 1'b0; in_data = 8'h00; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_oe_n && sda_oe_n, "R1 lines released", {scl_oe_n, sda_oe_n}, 3);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(out_valid == 1'b0 && ack_seen == 1'b0, "R1 strobe/flag", {out_valid, ack_seen}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 start opcode outside a packet is ignored
    s0 = starts;
    put(8'h74);
    repeat (40) @(negedge clk);
    chk(starts == s0, "R2 no start outside packet", starts - s0, 0);
    chk(sda_oe_n == 1'b1, "R2 sda released", sda_oe_n, 1);

    // R4 write burst at reset rate, R9 back-pressure, R8 default rate
    w0 = wn; s0 = starts; p0 = stops;
    put(8'hAA);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h74;
    while (!in_ready) @(negedge clk);
    @(negedge clk); in_valid = 1'b0;
    chk(in_ready == 1'b0, "R9 ready low during start", in_ready, 0);
    put(8'h83); put(8'hA0); put(8'h5B); put(8'hC7); put(8'h75); put(8'h00);
    chk(wn - w0 == 3, "R4 byte count", wn - w0, 3);
    chk(wlog[w0] == 8'hA0 && wlog[w0+1] == 8'h5B && wlog[w0+2] == 8'hC7, "R4 byte order",
        {wlog[w0], wlog[w0+1], wlog[w0+2]}, 32'hA05BC7);
    chk(hi_t == 30, "R8 default 100k high time", hi_t, 30);
    chk(ack_seen == 1'b1, "R5 ack seen", ack_seen, 1);
    chk(starts - s0 == 1 && stops - p0 == 1, "R3 start/stop", (starts - s0) * 16 + stops - p0, 17);

    // R5 missing acknowledge does not stop the burst
    slv_ack = 1'b0; w0 = wn;
    put(8'hAA); put(8'h74); put(8'h82); put(8'hA2); put(8'h19); put(8'h75); put(8'h00);
    chk(wn - w0 == 2, "R5 burst continues after nack", wn - w0, 2);
    chk(ack_seen == 1'b0, "R5 nack seen", ack_seen, 0);
    slv_ack = 1'b1;

    // R10 opcode after close is ignored
    s0 = starts;
    put(8'h74);
    repeat (40) @(negedge clk);
    chk(starts == s0 && sda_oe_n, "R10 ignored after close", starts - s0, 0);

    // table: rate select, addressed read bursts
    for (int i = 0; i < 5; i++) begin
      sp = int'(VEC[i][23:22]); n = int'(VEC[i][21:16]); seed = VEC[i][15:8];
      r0 = rcount; a0 = racks; n0 = rnacks; s0 = starts; p0 = stops;
      put(8'hAA); put(8'h60 | 8'(sp)); put(8'h74); put(8'h81); put(8'hA1);
      if (n > 1) put(8'hC0 | 8'(n - 1));
      put(8'hC0); put(8'h75); put(8'h00);
      chk(rcount - r0 == n, "R6 read count", rcount - r0, n);
      for (int k = 0; k < n; k++)
        chk(rbuf[r0 + k] == seed + 8'(k + 1), "R6 read data", rbuf[r0 + k], seed + 8'(k + 1));
      chk(racks - a0 == n - 1, "R6 acked reads", racks - a0, n - 1);
      chk(rnacks - n0 == 1, "R7 final byte nack", rnacks - n0, 1);
      chk(hi_t == int'(VEC[i][7:0]), "R8 SCL high time", hi_t, int'(VEC[i][7:0]));
      chk(ack_seen == 1'b1, "R5 address acked", ack_seen, 1);
      chk(starts - s0 == 1 && stops - p0 == 1, "R3 one start one stop",
          (starts - s0) * 16 + stops - p0, 17);
    end

    // R11 packet boundary drops unfinished write burst
    seed = 8'h00;
    put(8'hAA); put(8'h63); put(8'h00);
    w0 = wn; s0 = starts; p0 = stops;
    put(8'hAA); put(8'h74); put(8'h9F); put(8'hA0);
    for (int k = 1; k < 29; k++) put(8'(k));
    put(8'h74);
    repeat (40) @(negedge clk);
    chk(wn - w0 == 29, "R11 bytes up to boundary", wn - w0, 29);
    chk(starts - s0 == 1, "R11 byte after boundary ignored", starts - s0, 1);
    chk(wlog[w0 + 28] == 8'd28, "R11 last byte", wlog[w0 + 28], 28);
    put(8'hAA); put(8'h75); put(8'h00);
    chk(stops - p0 == 1, "R11 stop after new packet", stops - p0, 1);

    summary();
  end

endmodule